// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers a large set of maskable peripheral interrupt requests together with a small group of nonmaskable trap requests. It reduces them to one request line toward the CPU. Alongside that line it presents the number of the winning vector, the effective priority of that vector, and the program-memory address of the vector's table entry. The CPU uses that address to fetch the handler start address.

Every maskable source has a request, an enable and a 3-bit user level. The user level is combined with a fixed ordering by vector position. Traps sit above every maskable source and are never masked. One select input chooses between a primary vector table and an alternate table with the same layout.

Once a winner is chosen, it is held until the CPU acknowledges it. The acknowledge produces a one-cycle clear strobe back to the source that won.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, cpu_req_o is 0 and every trap_clr_o and irq_clr_o bit is 0.
- R2: A maskable source i competes only when three conditions hold: irq_req_i[i] and irq_en_i[i] are 1, its level irq_lvl_i[3*i+2:3*i] is nonzero, and that level is strictly greater than cpu_lvl_i. A level of 0 disables the source.
- R3: Among competing maskable sources, the one with the higher user level is served first.
- R4: Maskable source i is vector NUM_TRAPS+i. Among sources with equal user level, the lower vector number is served first.
- R5: Trap t is vector t and is served at effective level 15-t. It ignores the enables and cpu_lvl_i and outranks every maskable source. A lower trap number wins over a higher one.
- R6: When cpu_req_o is 0 and a competing request exists, cpu_req_o rises exactly one clock cycle later.
- R7: While cpu_req_o is 1 and ack_i is 0, vec_o, lvl_o and addr_o hold their values. For a maskable winner, lvl_o is its user level.
- R8: addr_o equals base + 2*vec_o. The base is 0x000004 when alt_tbl_i was 0 and 0x000104 when it was 1, sampled in the cycle the winner was captured.
- R9: When ack_i is 1 while cpu_req_o is 1, exactly one clear strobe is 1 in that cycle: trap_clr_o[vec_o] for a trap, or irq_clr_o[vec_o-NUM_TRAPS] for a maskable source. cpu_req_o is 0 in the next cycle. When ack_i is 1 while cpu_req_o is 0, it produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_req_i | input | NUM_TRAPS | Nonmaskable trap requests |
| irq_req_i | input | NUM_IRQ | Maskable source requests |
| irq_en_i | input | NUM_IRQ | Per-source enables |
| irq_lvl_i | input | 3*NUM_IRQ | Per-source user level, 3 bits per source |
| cpu_lvl_i | input | 4 | Current CPU priority level |
| alt_tbl_i | input | 1 | 1 selects the alternate vector table |
| ack_i | input | 1 | CPU acknowledge of the presented vector |
| cpu_req_o | output | 1 | Interrupt request toward the CPU |
| vec_o | output | clog2(NUM_TRAPS+NUM_IRQ) | Winning vector number |
| lvl_o | output | 4 | Effective level of the winner |
| addr_o | output | ADDR_W | Table entry address of the winner |
| trap_clr_o | output | NUM_TRAPS | One-cycle clear strobe per trap |
| irq_clr_o | output | NUM_IRQ | One-cycle clear strobe per maskable source |

## Verification
The bench builds the block with NUM_TRAPS=8 and NUM_IRQ=12, which gives 20 vectors and a 5-bit vector number. The table bases and the address width keep their default values. At this size every trap and the highest-numbered maskable source can be driven directly, and each address computed for both tables can be checked by hand. The bench also covers several scenarios: a trap arriving while a maskable winner is being held, masking by the CPU level on both sides of the strict comparison, and switching the table select between two requests.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned ULVL_W = 3;
  localparam int unsigned ELVL_W = 4;
  typedef logic [ELVL_W-1:0] elvl_t;
  localparam int unsigned TRAP_TOP = 15;
endpackage

// File: rtl/ivc_qualify.sv
module ivc_qualify
  import ivc_pkg::*;
#(
  parameter int unsigned NUM_TRAPS = 8,
  parameter int unsigned NUM_IRQ   = 118,
  localparam int unsigned NUM_VEC  = NUM_TRAPS + NUM_IRQ
) (
  input  logic [NUM_TRAPS-1:0]      trap_req_i,
  input  logic [NUM_IRQ-1:0]        irq_req_i,
  input  logic [NUM_IRQ-1:0]        irq_en_i,
  input  logic [ULVL_W*NUM_IRQ-1:0] irq_lvl_i,
  input  elvl_t                     cpu_lvl_i,
  output elvl_t                     eff_o [NUM_VEC]
);
  // traps: fixed effective levels 15 downwards, never masked
  for (genvar t = 0; t < NUM_TRAPS; t++) begin : g_trap
    localparam int unsigned TL = TRAP_TOP - t;
    assign eff_o[t] = trap_req_i[t] ? elvl_t'(TL) : '0;
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    elvl_t ul;
    assign ul = {1'b0, irq_lvl_i[ULVL_W*k +: ULVL_W]};
    assign eff_o[NUM_TRAPS+k] =
      (irq_req_i[k] && irq_en_i[k] && (ul != '0) && (ul > cpu_lvl_i)) ? ul : '0;
  end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
#(
  parameter int unsigned NUM_VEC = 126,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC)
) (
  input  elvl_t             lvl_i [NUM_VEC],
  output logic              valid_o,
  output logic [VEC_W-1:0]  vec_o,
  output elvl_t             lvl_o
);
  // ascending scan, strict compare: ties keep the lower vector
  always_comb begin
    lvl_o = '0;
    vec_o = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (lvl_i[v] > lvl_o) begin
        lvl_o = lvl_i[v];
        vec_o = VEC_W'(v);
      end
    end
  end
  assign valid_o = (lvl_o != '0);
endmodule

// File: rtl/ivc_addr_gen.sv
module ivc_addr_gen #(
  parameter int unsigned VEC_W    = 7,
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned PRI_BASE = 'h4,
  parameter int unsigned ALT_BASE = 'h104
) (
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              alt_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base;
  assign base   = alt_i ? ADDR_W'(ALT_BASE) : ADDR_W'(PRI_BASE);
  assign addr_o = base + (ADDR_W'(vec_i) << 1);
endmodule

// File: rtl/ivc_hold.sv
module ivc_hold
  import ivc_pkg::*;
#(
  parameter int unsigned VEC_W  = 7,
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_valid_i,
  input  logic [VEC_W-1:0]  win_vec_i,
  input  elvl_t             win_lvl_i,
  input  logic [ADDR_W-1:0] win_addr_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic [VEC_W-1:0]  vec_o,
  output elvl_t             lvl_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      vec_o  <= '0;
      lvl_o  <= '0;
      addr_o <= '0;
    end else if (!busy_o) begin
      if (win_valid_i) begin
        busy_o <= 1'b1;
        vec_o  <= win_vec_i;
        lvl_o  <= win_lvl_i;
        addr_o <= win_addr_i;
      end
    end else if (ack_i) begin
      busy_o <= 1'b0;
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && win_valid_i) |=> busy_o); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ack_i) |=> (busy_o && $stable(vec_o) && $stable(lvl_o) && $stable(addr_o))); // R7
  AST_DROP_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ack_i) |=> !busy_o); // R9
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int unsigned NUM_TRAPS = 8,
  parameter int unsigned NUM_IRQ   = 118,
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned PRI_BASE  = 'h4,
  parameter int unsigned ALT_BASE  = 'h104,
  localparam int unsigned NUM_VEC  = NUM_TRAPS + NUM_IRQ,
  localparam int unsigned VEC_W    = $clog2(NUM_VEC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_TRAPS-1:0]      trap_req_i,
  input  logic [NUM_IRQ-1:0]        irq_req_i,
  input  logic [NUM_IRQ-1:0]        irq_en_i,
  input  logic [ULVL_W*NUM_IRQ-1:0] irq_lvl_i,
  input  logic [ELVL_W-1:0]         cpu_lvl_i,
  input  logic                      alt_tbl_i,
  input  logic                      ack_i,
  output logic                      cpu_req_o,
  output logic [VEC_W-1:0]          vec_o,
  output logic [ELVL_W-1:0]         lvl_o,
  output logic [ADDR_W-1:0]         addr_o,
  output logic [NUM_TRAPS-1:0]      trap_clr_o,
  output logic [NUM_IRQ-1:0]        irq_clr_o
);
  elvl_t             eff_lvl [NUM_VEC];
  logic              win_valid;
  logic [VEC_W-1:0]  win_vec;
  elvl_t             win_lvl;
  logic [ADDR_W-1:0] win_addr;
  logic [NUM_VEC-1:0] clr_all;
  logic              ack_hit;

  ivc_qualify #(.NUM_TRAPS(NUM_TRAPS), .NUM_IRQ(NUM_IRQ)) i_qualify (
    .trap_req_i (trap_req_i),
    .irq_req_i  (irq_req_i),
    .irq_en_i   (irq_en_i),
    .irq_lvl_i  (irq_lvl_i),
    .cpu_lvl_i  (cpu_lvl_i),
    .eff_o      (eff_lvl)
  );

  ivc_arbiter #(.NUM_VEC(NUM_VEC)) i_arbiter (
    .lvl_i   (eff_lvl),
    .valid_o (win_valid),
    .vec_o   (win_vec),
    .lvl_o   (win_lvl)
  );

  ivc_addr_gen #(
    .VEC_W(VEC_W), .ADDR_W(ADDR_W), .PRI_BASE(PRI_BASE), .ALT_BASE(ALT_BASE)
  ) i_addr_gen (
    .vec_i  (win_vec),
    .alt_i  (alt_tbl_i),
    .addr_o (win_addr)
  );

  ivc_hold #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) i_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_valid_i (win_valid),
    .win_vec_i   (win_vec),
    .win_lvl_i   (win_lvl),
    .win_addr_i  (win_addr),
    .ack_i       (ack_i),
    .busy_o      (cpu_req_o),
    .vec_o       (vec_o),
    .lvl_o       (lvl_o),
    .addr_o      (addr_o)
  );

  assign ack_hit = cpu_req_o && ack_i;
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_clr
    assign clr_all[v] = ack_hit && (vec_o == VEC_W'(v));
  end
  assign trap_clr_o = clr_all[NUM_TRAPS-1:0];
  assign irq_clr_o  = clr_all[NUM_VEC-1:NUM_TRAPS];

  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_clr_o, trap_clr_o})); // R9
  AST_CLR_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|{irq_clr_o, trap_clr_o}) |-> (ack_i && cpu_req_o))); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && cpu_req_o) |-> ($countones({irq_clr_o, trap_clr_o}) == 1)); // R9
  AST_TRAP_RANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_o && (vec_o < VEC_W'(NUM_TRAPS))) |-> (lvl_o >= ELVL_W'(8))); // R5
  AST_IRQ_RANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_o && (vec_o >= VEC_W'(NUM_TRAPS))) |-> (lvl_o <= ELVL_W'(7) && lvl_o != '0)); // R7
  AST_MASK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cpu_req_o) && (vec_o >= VEC_W'(NUM_TRAPS))) |-> (lvl_o > $past(cpu_lvl_i))); // R2
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam int NT = 8;
  localparam int NI = 12;
  localparam int NV = NT + NI;
  localparam int VW = $clog2(NV);
  localparam int AW = 24;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NT-1:0]   trap_req = '0;
  logic [NI-1:0]   irq_req = '0;
  logic [NI-1:0]   irq_en = '1;
  logic [3*NI-1:0] irq_lvl = '0;
  logic [3:0]      cpu_lvl = '0;
  logic            alt = 1'b0;
  logic            ack = 1'b0;
  logic            cpu_req;
  logic [VW-1:0]   vec;
  logic [3:0]      lvl;
  logic [AW-1:0]   addr;
  logic [NT-1:0]   trap_clr;
  logic [NI-1:0]   irq_clr;

  always #4 clk_i = ~clk_i;

  irq_vector_ctrl #(.NUM_TRAPS(NT), .NUM_IRQ(NI), .ADDR_W(AW)) i_irq_vector_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .trap_req_i(trap_req), .irq_req_i(irq_req), .irq_en_i(irq_en), .irq_lvl_i(irq_lvl),
    .cpu_lvl_i(cpu_lvl), .alt_tbl_i(alt), .ack_i(ack),
    .cpu_req_o(cpu_req), .vec_o(vec), .lvl_o(lvl), .addr_o(addr),
    .trap_clr_o(trap_clr), .irq_clr_o(irq_clr)
  );

  typedef struct { int vec; int lvl; int addr; } item_t;
  item_t exp_q[$];
  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_exp(int v, int l);
    item_t it;
    it.vec = v; it.lvl = l;
    it.addr = (alt ? 'h104 : 'h4) + 2 * v;
    exp_q.push_back(it);
  endtask

  task automatic set_irq(int k, int l, bit en);
    irq_lvl[3*k +: 3] = 3'(l);
    irq_en[k] = en;
    irq_req[k] = 1'b1;
  endtask

  task automatic wait_idle();
    do @(negedge clk_i); while (exp_q.size() != 0 || cpu_req || ack);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic quiet(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      check(!cpu_req, req, int'(cpu_req), 0);
    end
  endtask

  // monitor: compare presented vector with scoreboard, then acknowledge
  bit   seen = 0;
  item_t cur;
  logic [VW-1:0] h_vec;
  logic [3:0]    h_lvl;
  logic [AW-1:0] h_addr;
  always @(negedge clk_i) begin
    if (ack) begin
      ack = 1'b0;
      check(!cpu_req, "R9 drop after ack", int'(cpu_req), 0);
    end else if (cpu_req) begin
      if (!seen) begin
        seen = 1;
        h_vec = vec; h_lvl = lvl; h_addr = addr;
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected request vec", int'(vec), -1);
        end else begin
          cur = exp_q.pop_front();
          check(int'(vec) == cur.vec, "R3/R4/R5 vec", int'(vec), cur.vec);
          check(int'(lvl) == cur.lvl, "R5/R7 lvl", int'(lvl), cur.lvl);
          check(int'(addr) == cur.addr, "R8 addr", int'(addr), cur.addr);
        end
      end else begin
        check(vec == h_vec && lvl == h_lvl && addr == h_addr, "R7 stable vec", int'(vec), int'(h_vec));
        seen = 0;
        ack = 1'b1;
        #1;
        check({irq_clr, trap_clr} == (NV'(1) << vec), "R9 clear strobe",
              int'({irq_clr, trap_clr}), int'(NV'(1) << vec));
        if (int'(vec) < NT) trap_req[vec] = 1'b0;
        else irq_req[int'(vec) - NT] = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(!cpu_req, "R1 cpu_req reset", int'(cpu_req), 0);
    check(trap_clr == '0 && irq_clr == '0, "R1 strobes reset", int'({irq_clr, trap_clr}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R6: single source, fixed latency
    set_irq(3, 4, 1);
    push_exp(NT + 3, 4);
    check(!cpu_req, "R6 not yet", int'(cpu_req), 0);
    @(negedge clk_i);
    check(cpu_req, "R6 one cycle later", int'(cpu_req), 1);
    wait_idle();

    // R4: equal levels, lower vector first
    @(negedge clk_i);
    set_irq(9, 5, 1); set_irq(2, 5, 1); set_irq(5, 5, 1);
    push_exp(NT + 2, 5); push_exp(NT + 5, 5); push_exp(NT + 9, 5);
    wait_idle();

    // R3: differing levels
    @(negedge clk_i);
    set_irq(1, 2, 1); set_irq(7, 6, 1); set_irq(4, 3, 1);
    push_exp(NT + 7, 6); push_exp(NT + 4, 3); push_exp(NT + 1, 2);
    wait_idle();

    // R2: masking by CPU level, enable and level 0
    @(negedge clk_i);
    cpu_lvl = 4'd4;
    set_irq(0, 4, 1); set_irq(6, 5, 1); set_irq(8, 7, 0); set_irq(10, 0, 1);
    push_exp(NT + 6, 5);
    wait_idle();
    quiet(4, "R2 masked stay idle");
    cpu_lvl = 4'd3;
    push_exp(NT + 0, 4);
    wait_idle();
    quiet(4, "R2 disabled and level0 ignored");
    irq_req[8] = 1'b0; irq_req[10] = 1'b0; irq_en[8] = 1'b1;

    // R5: traps ignore CPU level and outrank masked interrupts
    cpu_lvl = 4'd7;
    set_irq(2, 3, 1); set_irq(11, 7, 1);
    trap_req[5] = 1'b1; trap_req[1] = 1'b1;
    push_exp(1, 14); push_exp(5, 10);
    wait_idle();
    quiet(4, "R2 level equal to cpu masked");
    cpu_lvl = 4'd0;
    push_exp(NT + 11, 7); push_exp(NT + 2, 3);
    wait_idle();

    // R5: trap arriving while an interrupt is held
    @(negedge clk_i);
    set_irq(4, 6, 1); set_irq(5, 6, 1);
    push_exp(NT + 4, 6);
    @(negedge clk_i);
    trap_req[3] = 1'b1;
    push_exp(3, 12); push_exp(NT + 5, 6);
    wait_idle();

    // R8: table select toggled between requests
    @(negedge clk_i);
    alt = 1'b1;
    set_irq(0, 1, 1);
    push_exp(NT + 0, 1);
    wait_idle();
    alt = 1'b0;
    trap_req[7] = 1'b1;
    push_exp(7, 8);
    wait_idle();
    alt = 1'b1;
    trap_req[0] = 1'b1;
    push_exp(0, 15);
    wait_idle();

    // R9: ack while idle has no effect
    @(negedge clk_i);
    #2 ack = 1'b1;
    #1 check(trap_clr == '0 && irq_clr == '0, "R9 idle ack no strobe",
             int'({irq_clr, trap_clr}), 0);
    wait_idle();
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule